// File: doc/BRIEF.md
# SDRAM Bank State Tracker and Command Checker

This block sits beside the command bus of a four-bank synchronous DRAM and checks every cycle's command. It decodes chip select, the row strobe, the column strobe, write enable, the bank-select bits and address line A10. It keeps a small state machine and a set of cycle counters for each bank. It does not drive the bus, model the memory array, or look at data contents.

Each command is compared with the state of the bank it targets and with the state of the other banks. A command can be accepted on one bank and refused on another. Row-to-column delay, activate-to-activate spacing, precharge time, refresh cycle time, mode-set time and write recovery are all counted in clock cycles. For every command the block gives a verdict code one cycle later. Any refused command also sets a sticky error flag. The bank states are visible as an output so that a bench or a debug path can follow them.

Write recovery is counted from the last data beat. A write burst occupies `BURST_LEN` cycles starting with the write command, so a precharge is accepted only at distance `BURST_LEN-1+T_DPL` or more from that write.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Chip select high (deselect), or chip select low with the row strobe, column strobe and write enable all high (no-operation), gives verdict NOP and changes no bank. While chip select is low, {ras,cas,we} encodes the command as follows: 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode set. The unused pattern 110 is refused.
- R2: A precharge (A10=0) or a precharge-all (A10=1) when no bank is open gives verdict NOP.
- R3: Activate to an idle bank is accepted and moves that bank to ACTIVE. Activate to a bank that is not idle is refused, and this does not prevent an activate to another, idle bank.
- R4: An activate issued fewer than T_RRD cycles after the last accepted activate is refused.
- R5: Read or write (A10=1 selects auto-precharge) to a bank that is open and has no pending auto-precharge is accepted only at T_RCD or more cycles after its activate.
- R6: A plain read keeps the bank in READ for BURST_LEN cycles. A command issued at distance BURST_LEN from the read sees the bank in ACTIVE.
- R7: A precharge or precharge-all that covers a bank still within BURST_LEN-1+T_DPL cycles of its write is refused.
- R8: A bank leaves PRECHARGING for IDLE T_RP cycles after its precharge. An activate issued before that is refused. A single-bank precharge leaves the other banks unchanged.
- R9: A read with auto-precharge starts precharging at distance BURST_LEN. A write with auto-precharge starts precharging at distance BURST_LEN-1+T_DPL. The bank is IDLE T_RP cycles after precharging starts. Any non-NOP command to that bank before then is refused, and other banks are unaffected.
- R10: Refresh is accepted only when every bank is idle. All banks then stay in REFRESH for T_RC cycles, and any command other than DESL or NOP during that time is refused.
- R11: Mode set is accepted only when every bank is idle. All banks then stay in MODESET for T_MRD cycles.
- R12: Precharge-all is accepted when at least one bank is open and no bank is writing or has a pending auto-precharge. It moves every open bank to PRECHARGING.
- R13: Verdict codes are 0 legal, 1 NOP and 2 illegal, and each appears in the cycle after its command. After reset the verdict is NOP, the error flag is clear and all banks are IDLE. A refused command leaves the bank states unchanged and sets the error flag, which stays set until reset. Bank state codes are IDLE 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGING 4, REFRESH 5 and MODESET 6, with bank i in bits [3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankSel | input | BANK_W | Target bank of the command |
| addrA10 | input | 1 | Selects all-bank precharge, or auto-precharge on read and write |
| verdict | output | 2 | Verdict for the previous cycle's command |
| errorFlag | output | 1 | Sticky flag set by any refused command |
| bankStates | output | 3*2^BANK_W | Current state of each bank |

## Verification
The bench probes each timing window one cycle before it closes and again in the cycle it closes. A counter that is off by one would either refuse the first legal read, precharge or activate, or accept the last illegal one. It checks the burst end and the automatic precharge at the exact cycle where the bank state changes. A design that takes recovery from the write command instead of from the last data beat would then show PRECHARGING too early. It also mixes banks: a second activate to the same bank, a single-bank precharge next to an open bank, and a precharge-all while another bank is still in write recovery. A design that keeps one shared state, or that ignores the other banks, accepts or refuses the wrong one of these.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    BS_IDLE    = 3'd0,
    BS_ACTIVE  = 3'd1,
    BS_READ    = 3'd2,
    BS_WRITE   = 3'd3,
    BS_PRECH   = 3'd4,
    BS_REFRESH = 3'd5,
    BS_MODESET = 3'd6
  } bankState_t;

  typedef enum logic [1:0] {
    V_LEGAL   = 2'd0,
    V_NOP     = 2'd1,
    V_ILLEGAL = 2'd2
  } verdict_t;

  typedef enum logic [3:0] {
    C_DESL  = 4'd0,
    C_NOP   = 4'd1,
    C_READ  = 4'd2,
    C_WRITE = 4'd3,
    C_ACT   = 4'd4,
    C_PRE   = 4'd5,
    C_REF   = 4'd6,
    C_MRS   = 4'd7,
    C_UNDEF = 4'd8
  } cmdKind_t;

  // Control-to-datapath strobes for one bank
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic refresh;
    logic modeSet;
    logic autoPre;
  } bankStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic     csN,
  input  logic     rasN,
  input  logic     casN,
  input  logic     weN,
  output cmdKind_t cmdKind
);

  always_comb begin
    if (csN) begin
      cmdKind = C_DESL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  cmdKind = C_NOP;
        3'b101:  cmdKind = C_READ;
        3'b100:  cmdKind = C_WRITE;
        3'b011:  cmdKind = C_ACT;
        3'b010:  cmdKind = C_PRE;
        3'b001:  cmdKind = C_REF;
        3'b000:  cmdKind = C_MRS;
        default: cmdKind = C_UNDEF;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_judge.sv
module sdram_cmd_judge
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W    = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cmdKind_t                      cmdKind,
  input  logic [BANK_W-1:0]             bankSel,
  input  logic                          addrA10,
  input  bankState_t [NUM_BANKS-1:0]    viewState,
  input  logic [NUM_BANKS-1:0]          viewAp,
  input  logic [NUM_BANKS-1:0]          rcdOk,
  input  logic                          rrdOk,
  output bankStrobe_t [NUM_BANKS-1:0]   strobes,
  output verdict_t                      verdictQ,
  output logic                          errorQ
);

  verdict_t   verdictD;
  bankState_t tgtState;
  logic       anyLock, allIdle, anyOpen, anyBlock;

  always_comb begin
    anyLock  = 1'b0;
    allIdle  = 1'b1;
    anyOpen  = 1'b0;
    anyBlock = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (viewState[i] == BS_REFRESH || viewState[i] == BS_MODESET) anyLock = 1'b1;
      if (viewState[i] != BS_IDLE) allIdle = 1'b0;
      if (viewState[i] == BS_ACTIVE || (viewState[i] == BS_READ && !viewAp[i])) anyOpen = 1'b1;
      if (viewState[i] == BS_WRITE || viewAp[i]) anyBlock = 1'b1;
    end
  end

  assign tgtState = viewState[bankSel];

  always_comb begin
    verdictD = V_NOP;
    strobes  = '0;
    if (cmdKind == C_DESL || cmdKind == C_NOP) begin
      verdictD = V_NOP;
    end else if (anyLock) begin
      verdictD = V_ILLEGAL;
    end else begin
      case (cmdKind)
        C_ACT: begin
          if (tgtState == BS_IDLE && rrdOk) begin
            verdictD = V_LEGAL;
            strobes[bankSel].act = 1'b1;
          end else begin
            verdictD = V_ILLEGAL;
          end
        end
        C_READ, C_WRITE: begin
          if ((tgtState == BS_ACTIVE || tgtState == BS_READ || tgtState == BS_WRITE)
              && !viewAp[bankSel] && rcdOk[bankSel]) begin
            verdictD = V_LEGAL;
            strobes[bankSel].rd      = (cmdKind == C_READ);
            strobes[bankSel].wr      = (cmdKind == C_WRITE);
            strobes[bankSel].autoPre = addrA10;
          end else begin
            verdictD = V_ILLEGAL;
          end
        end
        C_PRE: begin
          if (addrA10) begin
            if (anyBlock) begin
              verdictD = V_ILLEGAL;
            end else if (anyOpen) begin
              verdictD = V_LEGAL;
              for (int i = 0; i < NUM_BANKS; i++) begin
                if (viewState[i] == BS_ACTIVE || viewState[i] == BS_READ) strobes[i].pre = 1'b1;
              end
            end else begin
              verdictD = V_NOP;
            end
          end else if (tgtState == BS_IDLE || tgtState == BS_PRECH) begin
            verdictD = V_NOP;
          end else if (tgtState == BS_WRITE || viewAp[bankSel]) begin
            verdictD = V_ILLEGAL;
          end else begin
            verdictD = V_LEGAL;
            strobes[bankSel].pre = 1'b1;
          end
        end
        C_REF: begin
          if (allIdle) begin
            verdictD = V_LEGAL;
            for (int i = 0; i < NUM_BANKS; i++) strobes[i].refresh = 1'b1;
          end else begin
            verdictD = V_ILLEGAL;
          end
        end
        C_MRS: begin
          if (allIdle) begin
            verdictD = V_LEGAL;
            for (int i = 0; i < NUM_BANKS; i++) strobes[i].modeSet = 1'b1;
          end else begin
            verdictD = V_ILLEGAL;
          end
        end
        default: verdictD = V_ILLEGAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictQ <= V_NOP;
      errorQ   <= 1'b0;
    end else begin
      verdictQ <= verdictD;
      errorQ   <= errorQ | (verdictD == V_ILLEGAL);
    end
  end

  // R13: the error flag never clears on its own
  assert_error_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    errorQ |=> errorQ);

  // R13: a reported refusal is always accompanied by the flag
  assert_illegal_flags_R13: assert property (@(posedge clk) disable iff (!rstN)
    (verdictQ == V_ILLEGAL) |-> errorQ);

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 6,
  parameter int T_RRD     = 2,
  parameter int T_DPL     = 2,
  parameter int T_MRD     = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobe_t [NUM_BANKS-1:0] strobes,
  output bankState_t  [NUM_BANKS-1:0] viewState,
  output logic [NUM_BANKS-1:0]        viewAp,
  output logic [NUM_BANKS-1:0]        rcdOk,
  output logic                        rrdOk
);

  localparam int CNT_MAX = maxOf(maxOf(T_RP, T_RC), maxOf(BURST_LEN + T_DPL, T_MRD));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int RCD_W   = $clog2(T_RCD + 1);
  localparam int RRD_W   = $clog2(T_RRD + 1);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RP_FULL  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(BURST_LEN + T_DPL - 2);
  localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(T_RCD - 1);
  localparam logic [RRD_W-1:0] RRD_LOAD = RRD_W'(T_RRD - 1);

  logic [NUM_BANKS-1:0] actVec;
  logic [NUM_BANKS-1:0] lockVec;
  logic [RRD_W-1:0]     rrdQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    bankState_t       stateQ, vState;
    logic [CNT_W-1:0] cntQ, vCnt;
    logic             apQ, vAp;
    logic [RCD_W-1:0] rcdQ;

    // Resolve counters that have run out into the state a command sees now
    always_comb begin
      vState = stateQ;
      vCnt   = cntQ;
      vAp    = apQ;
      if ((stateQ == BS_READ || stateQ == BS_WRITE) && cntQ == '0) begin
        vAp = 1'b0;
        if (apQ) begin
          vState = BS_PRECH;
          vCnt   = RP_FULL;
        end else begin
          vState = BS_ACTIVE;
        end
      end
      if ((vState == BS_PRECH || vState == BS_REFRESH || vState == BS_MODESET) && vCnt == '0)
        vState = BS_IDLE;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ <= BS_IDLE;
        cntQ   <= '0;
        apQ    <= 1'b0;
        rcdQ   <= '0;
      end else begin
        rcdQ <= (rcdQ == '0) ? '0 : rcdQ - RCD_W'(1);
        if (strobes[b].act) begin
          stateQ <= BS_ACTIVE;
          cntQ   <= '0;
          apQ    <= 1'b0;
          rcdQ   <= RCD_LOAD;
        end else if (strobes[b].rd) begin
          stateQ <= BS_READ;
          cntQ   <= RD_LOAD;
          apQ    <= strobes[b].autoPre;
        end else if (strobes[b].wr) begin
          stateQ <= BS_WRITE;
          cntQ   <= WR_LOAD;
          apQ    <= strobes[b].autoPre;
        end else if (strobes[b].pre) begin
          stateQ <= BS_PRECH;
          cntQ   <= RP_LOAD;
          apQ    <= 1'b0;
        end else if (strobes[b].refresh) begin
          stateQ <= BS_REFRESH;
          cntQ   <= RC_LOAD;
          apQ    <= 1'b0;
        end else if (strobes[b].modeSet) begin
          stateQ <= BS_MODESET;
          cntQ   <= MRD_LOAD;
          apQ    <= 1'b0;
        end else begin
          stateQ <= vState;
          cntQ   <= (vCnt == '0) ? '0 : vCnt - CNT_ONE;
          apQ    <= vAp;
        end
      end
    end

    assign viewState[b] = vState;
    assign viewAp[b]    = vAp;
    assign rcdOk[b]     = (rcdQ == '0);
    assign actVec[b]    = strobes[b].act;
    assign lockVec[b]   = (vState == BS_REFRESH);

    // R3: an activate only ever reaches a bank that is idle
    assert_act_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobes[b].act |-> (vState == BS_IDLE));

    // R5: column commands reach the bank only once its row delay has run out
    assert_rcd_window_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[b].rd || strobes[b].wr) |-> (rcdQ == '0));

    // R7: no precharge lands on a bank still in write recovery
    assert_dpl_window_R7: assert property (@(posedge clk) disable iff (!rstN)
      strobes[b].pre |-> (vState != BS_WRITE));

    // R8: an accepted precharge puts the bank in the precharging state
    assert_pre_enters_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobes[b].pre |=> (stateQ == BS_PRECH));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdQ <= '0;
    end else if (|actVec) begin
      rrdQ <= RRD_LOAD;
    end else if (rrdQ != '0) begin
      rrdQ <= rrdQ - RRD_W'(1);
    end
  end

  assign rrdOk = (rrdQ == '0);

  // R4: activates never come closer together than the spacing window
  assert_rrd_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|actVec) |-> (rrdQ == '0));

  // R10: refresh holds all banks together
  assert_refresh_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|lockVec) |-> (&lockVec));

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 6,
  parameter int T_RRD     = 2,
  parameter int T_DPL     = 2,
  parameter int T_MRD     = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     rasN,
  input  logic                     casN,
  input  logic                     weN,
  input  logic [BANK_W-1:0]        bankSel,
  input  logic                     addrA10,
  output logic [1:0]               verdict,
  output logic                     errorFlag,
  output logic [3*NUM_BANKS-1:0]   bankStates
);

  cmdKind_t                      cmdKind;
  bankStrobe_t [NUM_BANKS-1:0]   strobes;
  bankState_t  [NUM_BANKS-1:0]   viewState;
  logic [NUM_BANKS-1:0]          viewAp;
  logic [NUM_BANKS-1:0]          rcdOk;
  logic                          rrdOk;
  verdict_t                      verdictQ;

  sdram_cmd_decode uDecode (
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .cmdKind (cmdKind)
  );

  sdram_cmd_judge #(.BANK_W(BANK_W)) uJudge (
    .clk       (clk),
    .rstN      (rstN),
    .cmdKind   (cmdKind),
    .bankSel   (bankSel),
    .addrA10   (addrA10),
    .viewState (viewState),
    .viewAp    (viewAp),
    .rcdOk     (rcdOk),
    .rrdOk     (rrdOk),
    .strobes   (strobes),
    .verdictQ  (verdictQ),
    .errorQ    (errorFlag)
  );

  sdram_bank_track #(
    .BANK_W    (BANK_W),
    .BURST_LEN (BURST_LEN),
    .T_RP      (T_RP),
    .T_RCD     (T_RCD),
    .T_RC      (T_RC),
    .T_RRD     (T_RRD),
    .T_DPL     (T_DPL),
    .T_MRD     (T_MRD)
  ) uTrack (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .viewState (viewState),
    .viewAp    (viewAp),
    .rcdOk     (rcdOk),
    .rrdOk     (rrdOk)
  );

  assign verdict = verdictQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gOut
    assign bankStates[3*b +: 3] = viewState[b];
  end

endmodule

// File: tb/sdram_bank_monitor_test.sv
`timescale 1ns/1ps
module sdram_bank_monitor_test;

  localparam int K_DESL = 0, K_NOP = 1, K_READ = 2, K_WRIT = 3, K_ACT = 4,
                 K_PRE = 5, K_REF = 6, K_MRS = 7, K_UNDEF = 8;
  localparam logic [1:0] LEGAL = 2'd0, NOPV = 2'd1, ILL = 2'd2;
  localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_RD = 3'd2, S_WR = 3'd3,
                         S_PRE = 3'd4, S_REF = 3'd5, S_MRS = 3'd6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  bankSel = 2'd0;
  logic        addrA10 = 1'b0;
  logic [1:0]  verdict;
  logic        errorFlag;
  logic [11:0] bankStates;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sdram_bank_monitor #(
    .BANK_W(2), .BURST_LEN(4), .T_RP(3), .T_RCD(3), .T_RC(6),
    .T_RRD(2), .T_DPL(2), .T_MRD(2)
  ) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankSel(bankSel), .addrA10(addrA10), .verdict(verdict),
    .errorFlag(errorFlag), .bankStates(bankStates)
  );

  task automatic setPins(input int kind, input int bank, input bit a10);
    csN = 1'b0;
    bankSel = 2'(bank);
    addrA10 = a10;
    case (kind)
      K_DESL:  begin csN = 1'b1; {rasN, casN, weN} = 3'b111; end
      K_NOP:   {rasN, casN, weN} = 3'b111;
      K_READ:  {rasN, casN, weN} = 3'b101;
      K_WRIT:  {rasN, casN, weN} = 3'b100;
      K_ACT:   {rasN, casN, weN} = 3'b011;
      K_PRE:   {rasN, casN, weN} = 3'b010;
      K_REF:   {rasN, casN, weN} = 3'b001;
      K_MRS:   {rasN, casN, weN} = 3'b000;
      default: {rasN, casN, weN} = 3'b110;
    endcase
  endtask

  task automatic checkVerdict(input logic [1:0] exp, input string req);
    checks++;
    if (verdict !== exp) begin
      fails++;
      $display("FAIL %s: verdict actual=%0d expected=%0d", req, verdict, exp);
    end
  endtask

  task automatic checkState(input int bank, input logic [2:0] exp, input string req);
    checks++;
    if (bankStates[3*bank +: 3] !== exp) begin
      fails++;
      $display("FAIL %s: bank%0d state actual=%0d expected=%0d",
               req, bank, bankStates[3*bank +: 3], exp);
    end
  endtask

  task automatic checkError(input logic exp, input string req);
    checks++;
    if (errorFlag !== exp) begin
      fails++;
      $display("FAIL %s: errorFlag actual=%0b expected=%0b", req, errorFlag, exp);
    end
  endtask

  // Drive one command for one cycle, then check its verdict
  task automatic step(input int kind, input int bank, input bit a10,
                      input logic [1:0] expV, input string req);
    setPins(kind, bank, a10);
    @(negedge clk);
    setPins(K_NOP, 0, 1'b0);
    checkVerdict(expV, req);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) begin
      setPins(K_NOP, 0, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    checkVerdict(NOPV, "R13");
    checkError(1'b0, "R13");
    for (int b = 0; b < 4; b++) checkState(b, S_IDLE, "R13");
  endtask

  task automatic testIdleNoOps();
    step(K_DESL, 1, 1'b0, NOPV, "R1");
    step(K_NOP, 2, 1'b0, NOPV, "R1");
    step(K_PRE, 2, 1'b0, NOPV, "R2");
    step(K_PRE, 0, 1'b1, NOPV, "R2");
    checkError(1'b0, "R2");
    for (int b = 0; b < 4; b++) checkState(b, S_IDLE, "R1");
  endtask

  task automatic testRcdAndRead();
    step(K_ACT, 0, 1'b0, LEGAL, "R3");
    checkState(0, S_ACT, "R3");
    step(K_READ, 0, 1'b0, ILL, "R5");
    checkError(1'b1, "R13");
    checkState(0, S_ACT, "R13");
    step(K_UNDEF, 0, 1'b0, ILL, "R1");
    step(K_READ, 0, 1'b0, LEGAL, "R5");
    checkState(0, S_RD, "R6");
    nops(2);
    checkState(0, S_RD, "R6");
    nops(1);
    checkState(0, S_ACT, "R6");
  endtask

  task automatic testWriteRecovery();
    step(K_WRIT, 0, 1'b0, LEGAL, "R7");
    checkState(0, S_WR, "R7");
    nops(3);
    step(K_PRE, 0, 1'b0, ILL, "R7");
    step(K_PRE, 0, 1'b0, LEGAL, "R7");
    checkState(0, S_PRE, "R8");
    nops(1);
    step(K_ACT, 0, 1'b0, ILL, "R8");
    checkState(0, S_IDLE, "R8");
    step(K_ACT, 0, 1'b0, LEGAL, "R8");
  endtask

  task automatic testBankMix();
    step(K_ACT, 1, 1'b0, ILL, "R4");
    step(K_ACT, 1, 1'b0, LEGAL, "R4");
    nops(1);
    step(K_ACT, 1, 1'b0, ILL, "R3");
    step(K_PRE, 1, 1'b0, LEGAL, "R8");
    checkState(1, S_PRE, "R8");
    checkState(0, S_ACT, "R8");
    step(K_PRE, 1, 1'b1, LEGAL, "R12");
    checkState(0, S_PRE, "R12");
    nops(2);
    checkState(0, S_IDLE, "R12");
    checkState(1, S_IDLE, "R8");
  endtask

  task automatic testRefresh();
    step(K_ACT, 2, 1'b0, LEGAL, "R3");
    step(K_REF, 0, 1'b0, ILL, "R10");
    step(K_PRE, 0, 1'b1, LEGAL, "R12");
    nops(2);
    step(K_REF, 0, 1'b0, LEGAL, "R10");
    for (int b = 0; b < 4; b++) checkState(b, S_REF, "R10");
    step(K_ACT, 0, 1'b0, ILL, "R10");
    step(K_NOP, 0, 1'b0, NOPV, "R10");
    nops(2);
    checkState(3, S_REF, "R10");
    nops(1);
    checkState(0, S_IDLE, "R10");
  endtask

  task automatic testModeSet();
    step(K_MRS, 0, 1'b0, LEGAL, "R11");
    checkState(1, S_MRS, "R11");
    nops(1);
    checkState(1, S_IDLE, "R11");
    step(K_ACT, 1, 1'b0, LEGAL, "R11");
    step(K_MRS, 0, 1'b0, ILL, "R11");
    step(K_PRE, 1, 1'b0, LEGAL, "R11");
    nops(2);
  endtask

  task automatic testReadAuto();
    step(K_ACT, 3, 1'b0, LEGAL, "R9");
    nops(2);
    step(K_READ, 3, 1'b1, LEGAL, "R9");
    step(K_READ, 3, 1'b0, ILL, "R9");
    nops(1);
    checkState(3, S_RD, "R9");
    nops(1);
    checkState(3, S_PRE, "R9");
    nops(2);
    checkState(3, S_PRE, "R9");
    nops(1);
    checkState(3, S_IDLE, "R9");
  endtask

  task automatic testWriteAuto();
    step(K_ACT, 2, 1'b0, LEGAL, "R9");
    nops(1);
    step(K_ACT, 1, 1'b0, LEGAL, "R9");
    nops(1);
    step(K_WRIT, 2, 1'b1, LEGAL, "R9");
    step(K_PRE, 0, 1'b1, ILL, "R7");
    nops(2);
    checkState(2, S_WR, "R9");
    nops(1);
    checkState(2, S_PRE, "R9");
    nops(2);
    checkState(2, S_PRE, "R9");
    nops(1);
    checkState(2, S_IDLE, "R9");
    checkState(1, S_ACT, "R9");
    checkError(1'b1, "R13");
  endtask

  initial begin
    setPins(K_NOP, 0, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdleNoOps();
    testRcdAndRead();
    testWriteRecovery();
    testBankMix();
    testRefresh();
    testModeSet();
    testReadAuto();
    testWriteAuto();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule